// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

This block collects interrupt requests from a set of sources and drives the two active-low request lines of a processor: a normal line (`irq_n`) and a fast line (`fiq_n`). Each source is configured by software as edge or level triggered. Each one also has a priority from 0 to 7, an enable bit and a handler address. Source 0 does not take part in priority arbitration: it drives the fast line on its own and has its own vector read.

For the normal line, the block keeps a hardware stack of the priority levels currently being serviced. When the handler reads the normal vector register, it gets the address of the best eligible source, and that source's priority is pushed as the new current level. When the handler writes the end-of-interrupt register, the top level is popped. The normal line is requested only by sources whose priority is strictly above the level on top of the stack, so nested handling follows priority order. Registers are reached through a single-cycle synchronous bus. Read data is registered and appears on the edge that performs the access. The side effects of a vector read take effect on that same edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` and `fiq_n` are 1, the enable register (address 0x25) reads 0 and the error register (address 0x26) reads 0.
- R2: An edge-triggered source becomes pending on a 0-to-1 transition of its input. `irq_n` goes low only while a pending source is enabled, and a pending but disabled source asserts it as soon as it is enabled.
- R3: Writing address 0x23 sets the enable bits that are 1 in the data. Writing address 0x24 clears the enable bits that are 1 in the data. Bits written as 0 leave their enable unchanged. The enables read back at 0x25, with bit i for source i.
- R4: A read of address 0x20 returns the vector of the pending enabled source among 1..N-1 that has the highest priority above the current level. Between equal priorities, the lower source number wins.
- R5: A successful read of 0x20 pushes the winner's priority. Afterwards `irq_n` stays high unless a pending source has a priority strictly greater than that level. An equal priority does not preempt.
- R6: A write to address 0x22 pops the top level. `irq_n` is then asserted again if a pending enabled source is above the new level, even when its priority is not above the popped level. With an empty stack, a source of any priority counts.
- R7: An edge-triggered source is cleared by the read of 0x20 that selects it. A level-triggered source follows its input and is not cleared by any register access.
- R8: Source 0, when pending and enabled, drives `fiq_n` low and never `irq_n`. A read of address 0x21 returns its vector and, if it is edge triggered, clears it so that `fiq_n` returns high.
- R9: When source 0 is level triggered, a read of 0x21 leaves `fiq_n` low until the source input falls.
- R10: A pop of an empty stack, or a push onto a full stack, leaves the stack unchanged and sets bit 0 of address 0x26. That bit stays set until reset.
- R11: The per-source control word at address 0x00+i holds the trigger mode in bit 0 (1 = edge) and the priority in bits [6:4]. The vector is at address 0x10+i. Both read back what was written.
- R12: A read of 0x20 when no source is eligible returns 0 and pushes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Interrupt source inputs, active high; bit 0 is the fast source |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered on the access edge |
| irq_n | output | 1 | Normal interrupt request, active low, registered |
| fiq_n | output | 1 | Fast interrupt request, active low, registered |

## Verification
The assertions assume one bus access per strobe cycle, so a vector read and an end-of-interrupt write never fall in the same cycle. They also assume that the sources are synchronous to `clk`. The stack assertions take it that the priority pushed by a vector read is always above the current top. The stimulus changes source inputs and bus signals only on falling edges, holds each source pulse for two cycles, and issues each access as a lone one-cycle strobe. It allows several cycles between an access and the check of the request lines, because the inputs pass through two registers before reaching them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int A_MODE_BASE = 'h00;
   localparam int A_VEC_BASE  = 'h10;
   localparam int A_IVEC      = 'h20;
   localparam int A_FVEC      = 'h21;
   localparam int A_EOI       = 'h22;
   localparam int A_EN_SET    = 'h23;
   localparam int A_EN_CLR    = 'h24;
   localparam int A_EN        = 'h25;
   localparam int A_ERR       = 'h26;
   localparam int MODE_PRIO_LSB = 4;
endpackage

// File: rtl/irqc_src_pend.sv
module irqc_src_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic src_in,
   input  logic edge_mode,
   input  logic ack,
   output logic pend
);
   logic src_q;
   logic hit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         hit_q <= 1'b0;
      end else begin
         src_q <= src_in;
         if (src_in && !src_q)
            hit_q <= 1'b1;
         else if (ack)
            hit_q <= 1'b0;
      end
   end

   assign pend = edge_mode ? hit_q : src_q;

   // R7: a rising input is always captured, even when acknowledged in the same cycle
   a_r7_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (src_in && !src_q) |=> hit_q);
   // R7: an acknowledge with no new rising input leaves nothing latched
   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !(src_in && !src_q)) |=> !hit_q);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
   parameter int NSRC   = 8,
   parameter int PRIO_W = 3,
   localparam int IDX_W = $clog2(NSRC)
)(
   input  logic [NSRC-1:0]             req,
   input  logic [NSRC-1:0][PRIO_W-1:0] prio,
   input  logic                        lvl_valid,
   input  logic [PRIO_W-1:0]           lvl,
   output logic                        win_valid,
   output logic [IDX_W-1:0]            win_idx,
   output logic [PRIO_W-1:0]           win_prio
);
   logic unused_s0;
   assign unused_s0 = req[0] ^ (^prio[0]);

   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      win_prio  = '0;
      for (int i = 1; i < NSRC; i++) begin
         if (req[i] && (!lvl_valid || prio[i] > lvl) &&
             (!win_valid || prio[i] > win_prio)) begin
            win_valid = 1'b1;
            win_idx   = IDX_W'(i);
            win_prio  = prio[i];
         end
      end
   end
endmodule

// File: rtl/irqc_lvl_stack.sv
module irqc_lvl_stack #(
   parameter int DEPTH = 8,
   parameter int W     = 3,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_lvl,
   input  logic         pop,
   output logic [W-1:0] top_lvl,
   output logic         nonempty,
   output logic         err
);
   logic [W-1:0]     mem [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic [PTR_W-1:0] top_ptr;
   logic             full;

   assign full     = (cnt == CNT_W'(DEPTH));
   assign nonempty = (cnt != '0);
   assign top_ptr  = PTR_W'(cnt - 1'b1);
   assign top_lvl  = nonempty ? mem[top_ptr] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         err <= 1'b0;
      end else if (push) begin
         if (full) err <= 1'b1;
         else      cnt <= cnt + 1'b1;
      end else if (pop) begin
         if (!nonempty) err <= 1'b1;
         else           cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full)
         mem[PTR_W'(cnt)] <= push_lvl;
   end

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !nonempty) |=> (!nonempty && err));
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   a_r5_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NSRC   = 8,
   parameter int PRIO_W = 3,
   parameter int VEC_W  = 16,
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_in,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_n,
   output logic              fiq_n
);
   localparam int IDX_W = $clog2(NSRC);

   generate
      if (NSRC < 2 || NSRC > 16) begin : g_bad_nsrc
         $error("NSRC must lie in 2..16");
      end
      if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
         $error("PRIO_W must lie in 1..4");
      end
      if (VEC_W > DATA_W || NSRC > DATA_W || DATA_W < 8) begin : g_bad_data
         $error("DATA_W too narrow");
      end
      if (DEPTH < 1 || ADDR_W < 6) begin : g_bad_misc
         $error("DEPTH or ADDR_W out of range");
      end
   endgenerate

   logic [NSRC-1:0]             en_q, edge_q, pend, ack;
   logic [NSRC-1:0][PRIO_W-1:0] prio_q;
   logic [NSRC-1:0][VEC_W-1:0]  vec_q;
   logic                        arb_valid;
   logic [IDX_W-1:0]            arb_idx;
   logic [PRIO_W-1:0]           arb_prio, lvl_top;
   logic                        lvl_nonempty, stk_err, push;
   logic [DATA_W-1:0]           rd_mux;

   logic rd_acc, wr_acc, ivec_rd, fvec_rd, eoi_wr;
   assign rd_acc  = bus_sel && !bus_wr;
   assign wr_acc  = bus_sel && bus_wr;
   assign ivec_rd = rd_acc && (bus_addr == ADDR_W'(A_IVEC));
   assign fvec_rd = rd_acc && (bus_addr == ADDR_W'(A_FVEC));
   assign eoi_wr  = wr_acc && (bus_addr == ADDR_W'(A_EOI));
   assign push    = ivec_rd && arb_valid;

   always_comb begin
      ack = '0;
      if (push)    ack[arb_idx] = 1'b1;
      if (fvec_rd) ack[0]       = 1'b1;
   end

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_src
         irqc_src_pend u_pend (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_in    (src_in[g]),
            .edge_mode (edge_q[g]),
            .ack       (ack[g]),
            .pend      (pend[g])
         );
      end
   endgenerate

   irqc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
      .req       (pend & en_q),
      .prio      (prio_q),
      .lvl_valid (lvl_nonempty),
      .lvl       (lvl_top),
      .win_valid (arb_valid),
      .win_idx   (arb_idx),
      .win_prio  (arb_prio)
   );

   irqc_lvl_stack #(.DEPTH(DEPTH), .W(PRIO_W)) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_lvl (arb_prio),
      .pop      (eoi_wr),
      .top_lvl  (lvl_top),
      .nonempty (lvl_nonempty),
      .err      (stk_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         edge_q <= '0;
         prio_q <= '0;
         vec_q  <= '0;
      end else if (wr_acc) begin
         for (int i = 0; i < NSRC; i++) begin
            if (bus_addr == ADDR_W'(A_MODE_BASE + i)) begin
               edge_q[i] <= bus_wdata[0];
               prio_q[i] <= bus_wdata[MODE_PRIO_LSB +: PRIO_W];
            end
            if (bus_addr == ADDR_W'(A_VEC_BASE + i))
               vec_q[i] <= bus_wdata[VEC_W-1:0];
         end
         if (bus_addr == ADDR_W'(A_EN_SET)) en_q <= en_q | bus_wdata[NSRC-1:0];
         if (bus_addr == ADDR_W'(A_EN_CLR)) en_q <= en_q & ~bus_wdata[NSRC-1:0];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (bus_addr == ADDR_W'(A_MODE_BASE + i)) begin
            rd_mux[0]                      = edge_q[i];
            rd_mux[MODE_PRIO_LSB +: PRIO_W] = prio_q[i];
         end
         if (bus_addr == ADDR_W'(A_VEC_BASE + i))
            rd_mux[VEC_W-1:0] = vec_q[i];
      end
      if (bus_addr == ADDR_W'(A_IVEC) && arb_valid) rd_mux[VEC_W-1:0] = vec_q[arb_idx];
      if (bus_addr == ADDR_W'(A_FVEC))              rd_mux[VEC_W-1:0] = vec_q[0];
      if (bus_addr == ADDR_W'(A_EN))                rd_mux[NSRC-1:0]  = en_q;
      if (bus_addr == ADDR_W'(A_ERR))               rd_mux[0]         = stk_err;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         irq_n     <= 1'b1;
         fiq_n     <= 1'b1;
      end else begin
         if (rd_acc) bus_rdata <= rd_mux;
         irq_n <= !arb_valid;
         fiq_n <= !(pend[0] && en_q[0]);
      end
   end

   // R4/R5: whatever is pushed must lie strictly above the current level
   a_r4_push_above: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!lvl_nonempty || arb_prio > lvl_top));
   // R8: source 0 is never the winner of the normal arbitration
   a_r8_src0_excluded: assert property (@(posedge clk) disable iff (!rst_n)
      arb_valid |-> (arb_idx != '0));
   // R12: a vector read with nothing eligible leaves the stack depth alone
   a_r12_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      (ivec_rd && !arb_valid) |=> (lvl_nonempty == $past(lvl_nonempty) && lvl_top == $past(lvl_top)));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src_in = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_n, fiq_n;

   int checks = 0, failures = 0;
   logic [31:0] q_exp[$];
   string       q_tag[$];
   logic        rd_fire = 1'b0;

   always #2 clk = ~clk;

   prio_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_n(irq_n), .fiq_n(fiq_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares each registered read result with the queued expectation
   always @(posedge clk) rd_fire <= bus_sel && !bus_wr;
   always @(negedge clk) begin
      if (rd_fire) begin
         if (q_exp.size() == 0) chk("monitor unexpected read", 32'h1, 32'h0);
         else chk(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
      q_exp.push_back(exp); q_tag.push_back(tag);
      @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
      @(negedge clk); bus_sel = 0;
   endtask

   task automatic settle(); repeat (3) @(negedge clk); endtask

   task automatic pulse(input int s);
      @(negedge clk); src_in[s] = 1'b1;
      repeat (2) @(negedge clk); src_in[s] = 1'b0;
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq_n reset", {31'b0, irq_n}, 32'h1);
      chk("R1 fiq_n reset", {31'b0, fiq_n}, 32'h1);
      rd_exp(8'h25, 32'h0, "R1 enables reset");
      rd_exp(8'h26, 32'h0, "R1 error reset");

      // R11: configuration (bit0 edge, bits[6:4] priority)
      wr(8'h01, 32'h21); wr(8'h11, 32'h101);
      wr(8'h02, 32'h21); wr(8'h12, 32'h102);
      wr(8'h03, 32'h50); wr(8'h13, 32'h103);
      wr(8'h04, 32'h61); wr(8'h14, 32'h104);
      wr(8'h00, 32'h01); wr(8'h10, 32'h0F0);
      rd_exp(8'h03, 32'h50, "R11 mode word src3");
      rd_exp(8'h14, 32'h104, "R11 vector src4");

      // R3: set/clear enables
      wr(8'h23, 32'h1E); rd_exp(8'h25, 32'h1E, "R3 enable set");
      wr(8'h24, 32'h10); rd_exp(8'h25, 32'h0E, "R3 enable clear");
      wr(8'h23, 32'h10); wr(8'h23, 32'h00); rd_exp(8'h25, 32'h1E, "R3 zero bits no effect");

      // R2: disabled pending source stays quiet until enabled
      wr(8'h24, 32'h02);
      pulse(1); settle();
      chk("R2 disabled no irq", {31'b0, irq_n}, 32'h1);
      wr(8'h23, 32'h02); settle();
      chk("R2 enabled asserts irq", {31'b0, irq_n}, 32'h0);
      rd_exp(8'h20, 32'h101, "R4 vector src1");
      settle();
      chk("R7 edge cleared by vector read", {31'b0, irq_n}, 32'h1);

      // R5/R6: equal priority waits, reasserts after pop
      pulse(2); settle();
      chk("R5 equal priority no preempt", {31'b0, irq_n}, 32'h1);
      wr(8'h22, 32'h0); settle();
      chk("R6 reassert after pop", {31'b0, irq_n}, 32'h0);
      rd_exp(8'h20, 32'h102, "R6 vector src2");
      wr(8'h22, 32'h0); settle();
      chk("R6 idle after pop", {31'b0, irq_n}, 32'h1);

      // R4: tie goes to lower source number
      @(negedge clk); src_in[1] = 1; src_in[2] = 1;
      repeat (2) @(negedge clk); src_in[1] = 0; src_in[2] = 0;
      settle();
      rd_exp(8'h20, 32'h101, "R4 tie lower index");
      settle();
      chk("R5 tie loser waits", {31'b0, irq_n}, 32'h1);
      wr(8'h22, 32'h0); settle();
      rd_exp(8'h20, 32'h102, "R4 tie loser next");
      wr(8'h22, 32'h0); settle();

      // nesting with a level source
      pulse(1); settle();
      rd_exp(8'h20, 32'h101, "R4 nest base");
      @(negedge clk); src_in[3] = 1; settle();
      chk("R5 higher preempts", {31'b0, irq_n}, 32'h0);
      rd_exp(8'h20, 32'h103, "R4 level src3 vector");
      settle();
      chk("R5 level at own level quiet", {31'b0, irq_n}, 32'h1);
      pulse(4); settle();
      chk("R5 prio6 above 5", {31'b0, irq_n}, 32'h0);
      rd_exp(8'h20, 32'h104, "R4 vector src4");
      settle();
      chk("R5 irq after third push", {31'b0, irq_n}, 32'h1);
      wr(8'h22, 32'h0); settle();
      chk("R6 level 5 back on top", {31'b0, irq_n}, 32'h1);
      wr(8'h22, 32'h0); settle();
      chk("R7 level source not cleared", {31'b0, irq_n}, 32'h0);
      @(negedge clk); src_in[3] = 0; settle();
      chk("R7 level follows input", {31'b0, irq_n}, 32'h1);
      wr(8'h22, 32'h0); settle();
      chk("R7 edge src1 stays cleared", {31'b0, irq_n}, 32'h1);

      // R12 then R10
      rd_exp(8'h20, 32'h0, "R12 nothing eligible");
      rd_exp(8'h26, 32'h0, "R12 no error yet");
      wr(8'h22, 32'h0);
      rd_exp(8'h26, 32'h1, "R10 pop empty sets error");
      wr(8'h23, 32'h02); pulse(1); settle();
      chk("R10 stack unchanged by bad pop", {31'b0, irq_n}, 32'h0);
      rd_exp(8'h20, 32'h101, "R10 normal after error");
      wr(8'h22, 32'h0);
      rd_exp(8'h26, 32'h1, "R10 error sticky");

      // R8: fast source, edge
      wr(8'h23, 32'h01);
      pulse(0); settle();
      chk("R8 fiq asserted", {31'b0, fiq_n}, 32'h0);
      chk("R8 irq untouched", {31'b0, irq_n}, 32'h1);
      rd_exp(8'h21, 32'h0F0, "R8 fast vector");
      settle();
      chk("R8 edge fast cleared", {31'b0, fiq_n}, 32'h1);

      // R9: fast source, level
      wr(8'h00, 32'h00);
      @(negedge clk); src_in[0] = 1; settle();
      chk("R9 level fiq asserted", {31'b0, fiq_n}, 32'h0);
      rd_exp(8'h21, 32'h0F0, "R9 fast vector level");
      settle();
      chk("R9 read does not clear", {31'b0, fiq_n}, 32'h0);
      @(negedge clk); src_in[0] = 0; settle();
      chk("R9 released with input", {31'b0, fiq_n}, 32'h1);

      repeat (2) @(negedge clk);
      chk("monitor queue drained", q_exp.size(), 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule